// File: doc/BRIEF.md
# Card Data Port Address Sequencer

This block gives a host indirect access to a card address space through one 16-bit data window. The host loads a 32-bit address register as two halves. The upper half also carries qualifier bits: attribute-space select, a socket number, indirect-register select and I/O-cycle select. Every data-window access that is allowed turns into a card access request. The request carries the current address, a byte or word size and the direction. Read data from the card is passed straight back to the host.

A control byte enables card access and picks what happens to the address after each data-window access. The address can stay where it is (byte hold or word hold). It can step by the access size (auto-step). It can step two bytes per byte accessed, which suits attribute memory that exists only at even addresses (register-space step). Steps carry only within the 26-bit offset and wrap there, so the qualifier bits are never changed. Writing bit 7 of the control byte clears the address register and the control byte one cycle later.

Host word slots (`host_widx`): 0 = data window, 1 = address low half, 2 = address high half, 3 = control byte (low lane) and status byte (high lane, read-only).

Top module: `card_port_seq`

## Requirements
- R1: After reset the address register and the control byte read as zero.
- R2: Writes to slot 1 and slot 2 load address bits 15:0 and 31:16. Each byte lane is written only when its `host_be` bit is set, and the value reads back in the same slot.
- R3: A write to slot 3 with `host_be[0]` set loads the control byte. Control bits 1, 2 and 6 always read as zero. A read of slot 3 returns `{sock_status, control}`.
- R4: While control bit 0 is set, a data-window access with a nonzero `host_be` raises `card_req` in the same cycle. It drives `card_addr` with the current address, `card_word` = 1 when both lanes are enabled, `card_wr` = direction and `card_wdata` = `host_wdata`. A read returns `card_rdata` on `host_rdata`.
- R5: With control bits 4:3 = 0 (byte hold) or 1 (word hold), an access leaves the address unchanged.
- R6: With control bits 4:3 = 3 (auto-step), the offset grows by 1 after a byte access and by 2 after a word access.
- R7: With control bits 4:3 = 2 (register-space step), the offset grows by 2 after a byte access and by 4 after a word access.
- R8: A step carries only within address bits 25:0 and wraps modulo 2^26. Bits 31:26 are not changed.
- R9: While control bit 0 is clear, a data-window read returns 16'hFFFF. A data-window access raises no `card_req` and leaves the address unchanged.
- R10: A control write with bit 7 set clears the address register and the control byte on the following clock edge.
- R11: `card_reg_space`, `card_sock`, `card_indirect` and `card_io` equal address bits 31, 30:28, 27 and 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_widx | input | 3 | Host word slot index |
| host_be | input | 2 | Host byte-lane enables |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| sock_status | input | 8 | Socket status byte shown at slot 3 high lane |
| card_req | output | 1 | Card access request |
| card_wr | output | 1 | Request is a write |
| card_word | output | 1 | Request is 16 bits wide |
| card_addr | output | 32 | Address carried with the request |
| card_wdata | output | 16 | Write data for the card |
| card_rdata | input | 16 | Read data from the card |
| card_reg_space | output | 1 | Attribute-space qualifier |
| card_sock | output | 3 | Socket number qualifier |
| card_indirect | output | 1 | Indirect-register qualifier |
| card_io | output | 1 | I/O-cycle qualifier |

## Verification
The request, its address and size, and the host read data are combinational, so they are due in the same cycle as the access. The bench samples them one time unit after driving the inputs on the falling edge. Address steps and register writes take effect at the next rising edge, and the bench reads them back only on a later falling edge. The soft reset needs one extra edge. The bench reads the address and control after the second edge following the control write, so it never samples between the two edges.

// File: rtl/card_port_pkg.sv
package card_port_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 26;

  typedef enum logic [1:0] {
    MODE_BYTE_HOLD = 2'd0,
    MODE_WORD_HOLD = 2'd1,
    MODE_REG_STEP  = 2'd2,
    MODE_AUTO_STEP = 2'd3
  } incr_mode_e;

  localparam logic [7:0] CTRL_KEEP_MASK = 8'hB9;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_RST_BIT = 7;
  localparam int CTRL_MODE_LSB = 3;
endpackage

// File: rtl/card_port_ctrl.sv
module card_port_ctrl
  import card_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_q,
  output logic       soft_rst
);
  logic [7:0] ctrl_d;
  logic       pend_q, pend_d;

  always_comb begin
    pend_d = wr_en && wdata[CTRL_RST_BIT];
    ctrl_d = ctrl_q;
    if (pend_q)     ctrl_d = '0;
    else if (wr_en) ctrl_d = wdata & CTRL_KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pend_q <= pend_d;
    end
  end

  assign soft_rst = pend_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !pend_q |=> (ctrl_q & ~CTRL_KEEP_MASK) == 8'h00); // R3
endmodule

// File: rtl/card_port_step.sv
module card_port_step
  import card_port_pkg::*;
#(
  parameter int W = OFS_W
) (
  input  logic [W-1:0] ofs,
  input  incr_mode_e   mode,
  input  logic         is_word,
  output logic [W-1:0] ofs_next
);
  logic [2:0] inc;

  always_comb begin
    unique case (mode)
      MODE_AUTO_STEP: inc = is_word ? 3'd2 : 3'd1;
      MODE_REG_STEP:  inc = is_word ? 3'd4 : 3'd2;
      default:        inc = 3'd0;
    endcase
    ofs_next = ofs + W'(inc);
  end
endmodule

// File: rtl/card_port_addr.sv
module card_port_addr
  import card_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [1:0]        be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step_en,
  input  incr_mode_e        mode,
  input  logic              is_word,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_LSB = DATA_W;

  logic [ADDR_W-1:0] addr_d;
  logic [OFS_W-1:0]  ofs_next;

  card_port_step #(.W(OFS_W)) u_step (
    .ofs      (addr_q[OFS_W-1:0]),
    .mode     (mode),
    .is_word  (is_word),
    .ofs_next (ofs_next)
  );

  always_comb begin
    addr_d = addr_q;
    if (soft_rst) begin
      addr_d = '0;
    end else begin
      if (step_en) addr_d[OFS_W-1:0] = ofs_next;
      for (int b = 0; b < 2; b++) begin
        if (wr_lo && be[b]) addr_d[b*8 +: 8]          = wdata[b*8 +: 8];
        if (wr_hi && be[b]) addr_d[HI_LSB + b*8 +: 8] = wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !wr_lo && !wr_hi && !soft_rst &&
    (mode == MODE_BYTE_HOLD || mode == MODE_WORD_HOLD) |=> $stable(addr_q)); // R5
  AST_QUAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !wr_hi && !soft_rst |=>
    addr_q[ADDR_W-1:OFS_W] == $past(addr_q[ADDR_W-1:OFS_W])); // R8
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> addr_q == '0); // R10
endmodule

// File: rtl/card_port_seq.sv
module card_port_seq
  import card_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_widx,
  input  logic [1:0]  host_be,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  input  logic [7:0]  sock_status,
  output logic        card_req,
  output logic        card_wr,
  output logic        card_word,
  output logic [31:0] card_addr,
  output logic [15:0] card_wdata,
  input  logic [15:0] card_rdata,
  output logic        card_reg_space,
  output logic [2:0]  card_sock,
  output logic        card_indirect,
  output logic        card_io
);
  logic [7:0]        ctrl_q;
  logic              soft_rst;
  logic [ADDR_W-1:0] addr_q;
  logic              port_en, data_sel, data_acc, is_word;
  logic              wr_lo, wr_hi, wr_ctrl;
  incr_mode_e        mode;

  assign port_en  = ctrl_q[CTRL_EN_BIT];
  assign mode     = incr_mode_e'(ctrl_q[CTRL_MODE_LSB +: 2]);
  assign data_sel = (host_widx == 3'd0);
  assign data_acc = data_sel && (host_wr || host_rd) && (host_be != 2'b00) && port_en;
  assign is_word  = (host_be == 2'b11);
  assign wr_lo    = host_wr && (host_widx == 3'd1);
  assign wr_hi    = host_wr && (host_widx == 3'd2);
  assign wr_ctrl  = host_wr && (host_widx == 3'd3) && host_be[0];

  card_port_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ctrl),
    .wdata    (host_wdata[7:0]),
    .ctrl_q   (ctrl_q),
    .soft_rst (soft_rst)
  );

  card_port_addr u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .be       (host_be),
    .wdata    (host_wdata),
    .step_en  (data_acc),
    .mode     (mode),
    .is_word  (is_word),
    .addr_q   (addr_q)
  );

  assign card_req       = data_acc;
  assign card_wr        = data_acc && host_wr;
  assign card_word      = is_word;
  assign card_addr      = addr_q;
  assign card_wdata     = host_wdata;
  assign card_reg_space = addr_q[31];
  assign card_sock      = addr_q[30:28];
  assign card_indirect  = addr_q[27];
  assign card_io        = addr_q[26];

  always_comb begin
    unique case (host_widx)
      3'd0:    host_rdata = port_en ? card_rdata : 16'hFFFF;
      3'd1:    host_rdata = addr_q[15:0];
      3'd2:    host_rdata = addr_q[31:16];
      3'd3:    host_rdata = {sock_status, ctrl_q};
      default: host_rdata = 16'h0000;
    endcase
  end

  AST_DIS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !card_req); // R9
  AST_DIS_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en && data_sel && !soft_rst |=> $stable(addr_q)); // R9
endmodule

// File: tb/test_card_port_seq.sv
module test_card_port_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  host_widx;
  logic [1:0]  host_be;
  logic        host_wr, host_rd;
  logic [15:0] host_wdata, host_rdata;
  logic [7:0]  sock_status;
  logic        card_req, card_wr, card_word;
  logic [31:0] card_addr;
  logic [15:0] card_wdata, card_rdata;
  logic        card_reg_space, card_indirect, card_io;
  logic [2:0]  card_sock;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] c_rdata;
  logic        c_req, c_wr, c_word;
  logic [31:0] c_addr;
  logic [15:0] c_wdata;

  always #4 clk = ~clk;

  card_port_seq i_card_port_seq (
    .clk(clk), .rst_n(rst_n), .host_widx(host_widx), .host_be(host_be),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .sock_status(sock_status),
    .card_req(card_req), .card_wr(card_wr), .card_word(card_word),
    .card_addr(card_addr), .card_wdata(card_wdata), .card_rdata(card_rdata),
    .card_reg_space(card_reg_space), .card_sock(card_sock),
    .card_indirect(card_indirect), .card_io(card_io)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] widx, input logic [1:0] be,
                     input logic wr, input logic rd, input logic [15:0] wd);
    @(negedge clk);
    host_widx = widx; host_be = be; host_wr = wr; host_rd = rd; host_wdata = wd;
    #1;
    c_rdata = host_rdata; c_req = card_req; c_wr = card_wr;
    c_word = card_word; c_addr = card_addr; c_wdata = card_wdata;
    @(posedge clk); #1;
    host_wr = 1'b0; host_rd = 1'b0; host_be = 2'b00; host_widx = 3'd7;
  endtask

  task automatic rd_slot(input logic [2:0] widx, output logic [15:0] v);
    acc(widx, 2'b11, 1'b0, 1'b1, 16'h0);
    v = c_rdata;
  endtask

  task automatic set_addr(input logic [15:0] hi, input logic [15:0] lo);
    acc(3'd1, 2'b11, 1'b1, 1'b0, lo);
    acc(3'd2, 2'b11, 1'b1, 1'b0, hi);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd_slot(3'd1, v); chk("R1 addr lo", v, 16'h0000);
    rd_slot(3'd2, v); chk("R1 addr hi", v, 16'h0000);
    rd_slot(3'd3, v); chk("R1 ctrl", v[7:0], 8'h00);
  endtask

  task automatic t_addr_regs;
    logic [15:0] v;
    set_addr(16'hB5AB, 16'h1234);
    rd_slot(3'd1, v); chk("R2 lo readback", v, 16'h1234);
    rd_slot(3'd2, v); chk("R2 hi readback", v, 16'hB5AB);
    acc(3'd1, 2'b01, 1'b1, 1'b0, 16'h00FF);
    rd_slot(3'd1, v); chk("R2 lane write", v, 16'h12FF);
    chk("R11 reg space", card_reg_space, 1'b1);
    chk("R11 socket", card_sock, 3'd3);
    chk("R11 indirect", card_indirect, 1'b0);
    chk("R11 io", card_io, 1'b1);
  endtask

  task automatic t_ctrl;
    logic [15:0] v;
    sock_status = 8'h9C;
    acc(3'd3, 2'b01, 1'b1, 1'b0, 16'h007E);
    rd_slot(3'd3, v); chk("R3 ctrl and status", v, 16'h9C38);
  endtask

  task automatic t_hold;
    logic [15:0] v;
    acc(3'd3, 2'b01, 1'b1, 1'b0, 16'h0001);
    acc(3'd0, 2'b11, 1'b0, 1'b1, 16'h0);
    chk("R4 req", c_req, 1'b1);
    chk("R4 addr", c_addr, 32'hB5AB12FF);
    chk("R4 word", c_word, 1'b1);
    chk("R4 rdata", c_rdata, 16'hA5C3);
    chk("R4 rd dir", c_wr, 1'b0);
    rd_slot(3'd1, v); chk("R5 byte hold", v, 16'h12FF);
    acc(3'd3, 2'b01, 1'b1, 1'b0, 16'h0009);
    acc(3'd0, 2'b10, 1'b1, 1'b0, 16'h5A00);
    chk("R4 wr dir", c_wr, 1'b1);
    chk("R4 byte size", c_word, 1'b0);
    chk("R4 wdata", c_wdata, 16'h5A00);
    rd_slot(3'd1, v); chk("R5 word hold", v, 16'h12FF);
  endtask

  task automatic t_auto;
    logic [15:0] v;
    acc(3'd3, 2'b01, 1'b1, 1'b0, 16'h0019);
    set_addr(16'hB5AB, 16'h0010);
    acc(3'd0, 2'b01, 1'b0, 1'b1, 16'h0);
    rd_slot(3'd1, v); chk("R6 byte step", v, 16'h0011);
    acc(3'd0, 2'b11, 1'b1, 1'b0, 16'h1111);
    rd_slot(3'd1, v); chk("R6 word step", v, 16'h0013);
    rd_slot(3'd2, v); chk("R6 hi kept", v, 16'hB5AB);
  endtask

  task automatic t_reg;
    logic [15:0] v;
    acc(3'd3, 2'b01, 1'b1, 1'b0, 16'h0011);
    acc(3'd0, 2'b01, 1'b0, 1'b1, 16'h0);
    rd_slot(3'd1, v); chk("R7 byte step", v, 16'h0015);
    acc(3'd0, 2'b11, 1'b0, 1'b1, 16'h0);
    rd_slot(3'd1, v); chk("R7 word step", v, 16'h0019);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    acc(3'd3, 2'b01, 1'b1, 1'b0, 16'h0019);
    set_addr(16'hB7FF, 16'hFFFF);
    acc(3'd0, 2'b11, 1'b0, 1'b1, 16'h0);
    rd_slot(3'd1, v); chk("R8 wrap lo", v, 16'h0001);
    rd_slot(3'd2, v); chk("R8 wrap hi", v, 16'hB400);
  endtask

  task automatic t_disabled;
    logic [15:0] v;
    acc(3'd3, 2'b01, 1'b1, 1'b0, 16'h0018);
    set_addr(16'h0000, 16'h0040);
    acc(3'd0, 2'b11, 1'b0, 1'b1, 16'h0);
    chk("R9 read ones", c_rdata, 16'hFFFF);
    chk("R9 no req rd", c_req, 1'b0);
    acc(3'd0, 2'b11, 1'b1, 1'b0, 16'h7777);
    chk("R9 no req wr", c_req, 1'b0);
    rd_slot(3'd1, v); chk("R9 addr kept", v, 16'h0040);
  endtask

  task automatic t_soft_reset;
    logic [15:0] v;
    set_addr(16'h1234, 16'h5678);
    acc(3'd3, 2'b01, 1'b1, 1'b0, 16'h0099);
    @(negedge clk);
    rd_slot(3'd1, v); chk("R10 addr lo", v, 16'h0000);
    rd_slot(3'd2, v); chk("R10 addr hi", v, 16'h0000);
    rd_slot(3'd3, v); chk("R10 ctrl", v[7:0], 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_widx = 3'd7; host_be = 2'b00; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; sock_status = 8'h00; card_rdata = 16'hA5C3;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_addr_regs();
    t_ctrl();
    t_hold();
    t_auto();
    t_reg();
    t_wrap();
    t_disabled();
    t_soft_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule